// File: doc/BRIEF.md
# Peripheral Clock Gate Slot

This block is the clock-control slot that sits beside one peripheral. Software programs it through a small register port. The slot holds four things: a clock-control mode, a source select, a divider and an error flag. From these it turns one of four candidate source enable pulses into a divided, gated clock enable for the peripheral. It also drives the peripheral's reset release, and it can hold off entry into a low-power state until the peripheral has gone idle.

Each source arrives as a one-cycle enable pulse, and the slot passes one pulse in every divider+1 selected pulses. The mode decides whether the enable reaches the peripheral:

- Mode 0: always gated.
- Mode 1: always open.
- Mode 2: open unless the peripheral reports idle.
- Mode 3: open unless a sleep or deep-sleep request is present.

The source and divider fields may change only while the stored mode is 0. Software therefore first writes the slot with mode 0, then writes the new setting.

Top module: `pcg_slot`

Register layout (16 bits with the default 8-bit divider):

| Bits | Field | Access |
|------|-------|--------|
| [1:0] | mode | read/write |
| [2] | reset release | read-only |
| [3] | sticky error | write 1 to clear |
| [6:4] | source select | read/write |
| [7] | present flag | read-only |
| [15:8] | divider | read/write |

## Requirements
- R1: After reset every field reads zero except the present flag (bit 7, which reads 1 in the default build), so rd_data = 0x0080; clk_en, periph_rst_rel and lp_stall are all 0.
- R2: With mode 0, clk_en stays 0 for any source pulses and lp_stall stays 0 whatever the request and idle inputs.
- R3: With mode 1, every divided tick of the selected source appears on clk_en, regardless of periph_idle, sleep_req and deep_req, and lp_stall stays 0.
- R4: With mode 2, clk_en is suppressed while periph_idle is 1. lp_stall is 1 exactly when sleep_req or deep_req is 1 and periph_idle is 0.
- R5: With mode 3, clk_en is suppressed while sleep_req or deep_req is 1. Because a clock kept alive in sleep does not stall a plain sleep request, lp_stall is 1 exactly when deep_req is 1 and periph_idle is 0.
- R6: The divider passes one enable for every divider+1 pulses of the selected source, counting from a restarted counter. With divider 2, seven pulses give two enables.
- R7: Source codes 2, 3, 4 and 5 select src_en[0], src_en[1], src_en[2] and src_en[3]. Any other code produces no enable at all.
- R8: Each write sets the reset-release output (also read back in bit 2) to 1 if the present flag is 1 and the written mode is nonzero. A write with mode 0 sets it to 0.
- R9: A write that changes the source or divider while the stored mode is nonzero leaves those two fields unchanged, still updates the mode, and sets the sticky error bit 3. Writing 1 to bit 3 in a write that breaks no rule clears the error bit.
- R10: An accepted change of source or divider restarts the divider count from zero, so the first enable after the change needs a full divider+1 pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slot clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write value |
| rd_data | output | 16 | Register read value |
| src_en | input | 4 | One-cycle enable pulses of the four candidate sources |
| periph_idle | input | 1 | Peripheral reports idle |
| sleep_req | input | 1 | System sleep request |
| deep_req | input | 1 | System deep-sleep request |
| clk_en | output | 1 | Gated, divided clock enable to the peripheral |
| periph_rst_rel | output | 1 | Peripheral reset release (1 = out of reset) |
| lp_stall | output | 1 | Holds off low-power entry |

## Verification
The bench leaves a nonzero divider count in place, then makes a legal divider change and counts the enables. A design that forgot to restart the count would let an enable through one pulse early. It tries to retune the slot while the clock is running. A design without the lock would move the divider on the fly and not raise the error bit. It sets sleep and deep-sleep requests separately in mode 3. A design that treated a plain sleep request like deep sleep would stall entry for a clock that is allowed to stay alive. It sweeps source codes outside 2 to 5, which must produce no clock at all.

// File: rtl/pcg_pkg.sv
package pcg_pkg;

    localparam int NSRC  = 4;
    localparam int SEL_W = 3;
    localparam logic [SEL_W-1:0] SEL_BASE = 3'd2;

    localparam int POS_MODE = 0;
    localparam int POS_REL  = 2;
    localparam int POS_ERR  = 3;
    localparam int POS_SEL  = 4;
    localparam int POS_PRES = 7;
    localparam int POS_DIV  = 8;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_ON    = 2'd1,
        MODE_IDLE  = 2'd2,
        MODE_SLEEP = 2'd3
    } ccm_e;

    typedef struct packed {
        ccm_e             mode;
        logic             rel;
        logic             err;
        logic [SEL_W-1:0] sel;
    } ctl_t;

    // one-hot source mask for a select code; unused codes give zero
    function automatic logic [NSRC-1:0] sel_onehot(input logic [SEL_W-1:0] sel);
        logic [NSRC-1:0] m;
        m = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (sel == SEL_BASE + SEL_W'(i)) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/pcg_regs.sv
module pcg_regs
    import pcg_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter bit PRESENT = 1'b1,
    localparam int REG_W  = POS_DIV + DIV_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output ctl_t             ctl,
    output logic [DIV_W-1:0] div_q,
    output logic             restart,
    output logic [REG_W-1:0] rd_data
);

    ccm_e             w_mode;
    logic [SEL_W-1:0] w_sel;
    logic [DIV_W-1:0] w_div;
    logic             changed;
    logic             locked;
    logic             violate;

    always_comb begin
        w_mode  = ccm_e'(wr_data[POS_MODE +: 2]);
        w_sel   = wr_data[POS_SEL +: SEL_W];
        w_div   = wr_data[POS_DIV +: DIV_W];
        changed = (w_sel != ctl.sel) || (w_div != div_q);
        locked  = (ctl.mode != MODE_OFF);
        violate = wr_en && changed && locked;
        restart = wr_en && changed && !locked;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl   <= '0;
            div_q <= '0;
        end else if (wr_en) begin
            ctl.mode <= w_mode;
            ctl.rel  <= PRESENT && (w_mode != MODE_OFF);
            ctl.err  <= violate || (ctl.err && !wr_data[POS_ERR]);
            if (restart) begin
                ctl.sel <= w_sel;
                div_q   <= w_div;
            end
        end
    end

    always_comb begin
        rd_data                    = '0;
        rd_data[POS_MODE +: 2]     = ctl.mode;
        rd_data[POS_REL]           = ctl.rel;
        rd_data[POS_ERR]           = ctl.err;
        rd_data[POS_SEL +: SEL_W]  = ctl.sel;
        rd_data[POS_PRES]          = PRESENT;
        rd_data[POS_DIV +: DIV_W]  = div_q;
    end

endmodule

// File: rtl/pcg_divider.sv
module pcg_divider
    import pcg_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  src_en,
    input  logic [SEL_W-1:0] sel,
    input  logic [DIV_W-1:0] div,
    input  logic             restart,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;
    logic             pick;
    logic             wrap;

    always_comb begin
        pick = |(src_en & sel_onehot(sel));
        wrap = (cnt == div);
        tick = pick && wrap;
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (pick) begin
            cnt <= wrap ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/pcg_policy.sv
module pcg_policy
    import pcg_pkg::*;
#(
    parameter bit KEEP_IN_SLEEP = 1'b1
) (
    input  ccm_e mode,
    input  logic periph_idle,
    input  logic sleep_req,
    input  logic deep_req,
    output logic gate_open,
    output logic stall
);

    logic lp_req;

    always_comb begin
        lp_req = sleep_req || deep_req;
        unique case (mode)
            MODE_OFF: begin
                gate_open = 1'b0;
                stall     = 1'b0;
            end
            MODE_ON: begin
                gate_open = 1'b1;
                stall     = 1'b0;
            end
            MODE_IDLE: begin
                gate_open = !periph_idle;
                stall     = lp_req && !periph_idle;
            end
            default: begin
                gate_open = !lp_req;
                stall     = lp_req && !periph_idle && (deep_req || !KEEP_IN_SLEEP);
            end
        endcase
    end

endmodule

// File: rtl/pcg_slot.sv
module pcg_slot
    import pcg_pkg::*;
#(
    parameter int DIV_W         = 8,
    parameter bit PRESENT       = 1'b1,
    parameter bit KEEP_IN_SLEEP = 1'b1,
    localparam int REG_W        = POS_DIV + DIV_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic [NSRC-1:0]  src_en,
    input  logic             periph_idle,
    input  logic             sleep_req,
    input  logic             deep_req,
    output logic             clk_en,
    output logic             periph_rst_rel,
    output logic             lp_stall
);

    ctl_t             ctl;
    logic [DIV_W-1:0] div_q;
    logic             restart;
    logic             tick;
    logic             gate_open;

    pcg_regs #(.DIV_W(DIV_W), .PRESENT(PRESENT)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctl     (ctl),
        .div_q   (div_q),
        .restart (restart),
        .rd_data (rd_data)
    );

    pcg_divider #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .src_en  (src_en),
        .sel     (ctl.sel),
        .div     (div_q),
        .restart (restart),
        .tick    (tick)
    );

    pcg_policy #(.KEEP_IN_SLEEP(KEEP_IN_SLEEP)) u_pol (
        .mode        (ctl.mode),
        .periph_idle (periph_idle),
        .sleep_req   (sleep_req),
        .deep_req    (deep_req),
        .gate_open   (gate_open),
        .stall       (lp_stall)
    );

    assign clk_en         = tick && gate_open;
    assign periph_rst_rel = ctl.rel;

endmodule

// File: rtl/pcg_slot_chk.sv
module pcg_slot_chk #(
    parameter int DIV_W  = 8,
    localparam int REG_W = 8 + DIV_W
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic [REG_W-1:0] rd_data,
    input logic             periph_idle,
    input logic             sleep_req,
    input logic             deep_req,
    input logic             clk_en,
    input logic             periph_rst_rel,
    input logic             lp_stall
);

    AST_OFF_NO_CLOCK: assert property (@(posedge clk) disable iff (rst)
        (rd_data[1:0] == 2'd0) |-> (!clk_en && !lp_stall)); // R2

    AST_ON_NO_STALL: assert property (@(posedge clk) disable iff (rst)
        (rd_data[1:0] == 2'd1) |-> !lp_stall); // R3

    AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (rst)
        periph_idle |-> !lp_stall); // R4

    AST_SLEEP_GATES: assert property (@(posedge clk) disable iff (rst)
        ((rd_data[1:0] == 2'd3) && (sleep_req || deep_req)) |-> !clk_en); // R5

    AST_REL_NEEDS_MODE: assert property (@(posedge clk) disable iff (rst)
        periph_rst_rel |-> (rd_data[1:0] != 2'd0)); // R8

    AST_FIELDS_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (rd_data[1:0] != 2'd0)) |=>
        ((rd_data[6:4] == $past(rd_data[6:4])) &&
         (rd_data[REG_W-1:8] == $past(rd_data[REG_W-1:8])))); // R9

    AST_ERR_ON_VIOLATION: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (rd_data[1:0] != 2'd0) &&
         ((wr_data[6:4] != rd_data[6:4]) || (wr_data[REG_W-1:8] != rd_data[REG_W-1:8])))
        |=> rd_data[3]); // R9

endmodule

bind pcg_slot pcg_slot_chk #(.DIV_W(DIV_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .wr_en          (wr_en),
    .wr_data        (wr_data),
    .rd_data        (rd_data),
    .periph_idle    (periph_idle),
    .sleep_req      (sleep_req),
    .deep_req       (deep_req),
    .clk_en         (clk_en),
    .periph_rst_rel (periph_rst_rel),
    .lp_stall       (lp_stall)
);

// File: tb/pcg_slot_bench.sv
`timescale 1ns/1ps
module pcg_slot_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic [3:0]  src_en = '0;
    logic        periph_idle = 1'b0;
    logic        sleep_req = 1'b0;
    logic        deep_req = 1'b0;
    logic        clk_en;
    logic        periph_rst_rel;
    logic        lp_stall;

    int tests  = 0;
    int failed = 0;
    bit done   = 1'b0;

    typedef struct {
        string rq;
        int    exp;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    pcg_slot u_pcg_slot (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .src_en(src_en), .periph_idle(periph_idle), .sleep_req(sleep_req),
        .deep_req(deep_req), .clk_en(clk_en), .periph_rst_rel(periph_rst_rel),
        .lp_stall(lp_stall)
    );

    // driver side: queue the expected value
    task automatic push(input string rq, input int exp);
        exp_t e;
        e.rq  = rq;
        e.exp = exp;
        sb.push_back(e);
    endtask

    // monitor side: pop and compare against what the design produced
    task automatic observe(input int act);
        exp_t e;
        e = sb.pop_front();
        tests++;
        if (act != e.exp) begin
            failed++;
            $display("FAIL %s: actual %0h expected %0h", e.rq, act, e.exp);
        end
    endtask

    task automatic wr(input logic [15:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
        #1;
    endtask

    task automatic pulses(input logic [3:0] mask, input int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            src_en = mask;
            #1;
            if (clk_en) cnt++;
        end
        @(negedge clk);
        src_en = '0;
        #1;
    endtask

    task automatic lp(input logic s, input logic d, input logic idl);
        @(negedge clk);
        sleep_req   = s;
        deep_req    = d;
        periph_idle = idl;
        #1;
    endtask

    initial begin
        int c;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        push("R1 rd_data", 16'h0080);   observe(rd_data);
        push("R1 clk_en", 0);           observe(clk_en);
        push("R1 rst_rel", 0);          observe(periph_rst_rel);
        push("R1 stall", 0);            observe(lp_stall);

        // R2 mode 0 with a valid source
        wr(16'h0020);
        pulses(4'h1, 4, c);
        push("R2 gated pulses", 0);     observe(c);
        lp(1, 1, 0);
        push("R2 stall", 0);            observe(lp_stall);
        lp(0, 0, 0);

        // R3 mode 1, R8 release
        wr(16'h0021);
        push("R8 rel on", 1);           observe(periph_rst_rel);
        pulses(4'h1, 4, c);
        push("R3 on pulses", 4);        observe(c);
        lp(1, 1, 1);
        pulses(4'h1, 4, c);
        push("R3 on pulses asleep", 4); observe(c);
        lp(1, 1, 0);
        push("R3 stall", 0);            observe(lp_stall);
        lp(0, 0, 0);

        // R9 change while running is refused
        wr(16'h0231);
        push("R9 locked rd", 16'h00AD); observe(rd_data);
        wr(16'h0029);
        push("R9 err clear", 16'h00A5); observe(rd_data);

        // R8 release drops in mode 0; legal retune
        wr(16'h0020);
        push("R8 rel off", 0);          observe(periph_rst_rel);
        push("R8 rd", 16'h00A0);        observe(rd_data);
        wr(16'h0221);
        push("R9 accepted rd", 16'h02A5); observe(rd_data);
        pulses(4'h1, 7, c);
        push("R6 div3 count", 2);       observe(c);

        // R10 restart after change (count left at 1)
        wr(16'h0220);
        wr(16'h0321);
        pulses(4'h1, 3, c);
        push("R10 no early tick", 0);   observe(c);
        pulses(4'h1, 1, c);
        push("R10 tick on 4th", 1);     observe(c);

        // R7 source decode
        wr(16'h0320);
        wr(16'h0051);
        push("R7 rd", 16'h00D5);        observe(rd_data);
        pulses(4'h8, 3, c);
        push("R7 code5 src3", 3);       observe(c);
        pulses(4'h1, 3, c);
        push("R7 code5 ignores src0", 0); observe(c);
        wr(16'h0050);
        wr(16'h0061);
        pulses(4'hF, 3, c);
        push("R7 code6 none", 0);       observe(c);

        // R4 mode 2
        wr(16'h0060);
        wr(16'h0052);
        pulses(4'h8, 3, c);
        push("R4 busy pulses", 3);      observe(c);
        lp(0, 0, 1);
        pulses(4'h8, 3, c);
        push("R4 idle gated", 0);       observe(c);
        lp(1, 0, 0);
        push("R4 stall sleep busy", 1); observe(lp_stall);
        lp(1, 0, 1);
        push("R4 stall idle", 0);       observe(lp_stall);
        lp(0, 0, 0);
        push("R4 no req", 0);           observe(lp_stall);

        // R5 mode 3
        wr(16'h0053);
        push("R5 rd", 16'h00D7);        observe(rd_data);
        pulses(4'h8, 3, c);
        push("R5 awake pulses", 3);     observe(c);
        lp(1, 0, 0);
        pulses(4'h8, 3, c);
        push("R5 sleep gated", 0);      observe(c);
        push("R5 sleep no stall", 0);   observe(lp_stall);
        lp(0, 1, 0);
        pulses(4'h8, 3, c);
        push("R5 deep gated", 0);       observe(c);
        push("R5 deep stall", 1);       observe(lp_stall);
        lp(0, 1, 1);
        push("R5 deep idle", 0);        observe(lp_stall);
        lp(0, 0, 0);

        // back to mode 0
        wr(16'h0050);
        push("R8 rel off again", 0);    observe(periph_rst_rel);
        pulses(4'h8, 3, c);
        push("R2 gated again", 0);      observe(c);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            failed++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, failed);
            $finish;
        end
    end

endmodule